// File: doc/BRIEF.md
# Three-Level Alarm Escalator

This block is a Moore state machine that tracks an alarm level with three ordered steps: calm, warning and alert. Each cycle in which the `bad_event_i` pulse is sampled high moves the level up one step. The level stops at alert. While the level is alert, a bell request output is raised. A separate `clear_i` input returns the level to calm from any step. When both inputs are high in the same cycle, clear wins.

All outputs come straight from flip-flops. The level code is the state register itself. The one-hot level vector and the bell request are decoded from the next-state value and loaded on the same clock edge as the state. So every output changes on the first clock edge that samples the causing input, and no input reaches an output through logic alone. Reset is synchronous and active-high.

Top module: `alarm_level_fsm`

## Requirements
- R1: While `rst` is sampled high, and after it is released, the block is in calm: `level_code_o` = 0, `level_onehot_o` = 3'b001 and `ring_bell_o` = 0.
- R2: In calm, a sampled `bad_event_i` with `clear_i` low moves the block to warning: `level_code_o` = 1, `level_onehot_o` = 3'b010.
- R3: In warning, a sampled `bad_event_i` with `clear_i` low moves the block to alert: `level_code_o` = 2, `level_onehot_o` = 3'b100.
- R4: In alert, a sampled `bad_event_i` keeps the block in alert.
- R5: `ring_bell_o` is 1 exactly when the block is in alert (`level_code_o` = 2), and 0 in calm and warning.
- R6: A sampled `clear_i` returns the block to calm from any level.
- R7: When `bad_event_i` and `clear_i` are sampled high in the same cycle, the block goes to calm, the same result as clear alone.
- R8: With both inputs low, the level and all outputs keep their values.
- R9: Outputs change only on the clock edge that samples the causing input. Between that edge and the one before it, the outputs show the previous level.
- R10: `level_onehot_o` always has exactly one bit set, and that bit is the one at index `level_code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state is updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset to calm |
| bad_event_i | input | 1 | Escalation request, sampled each cycle |
| clear_i | input | 1 | Return-to-calm request; has priority over `bad_event_i` |
| level_code_o | output | 2 | Level code: 0 calm, 1 warning, 2 alert |
| level_onehot_o | output | 3 | One-hot level: bit 0 calm, bit 1 warning, bit 2 alert |
| ring_bell_o | output | 1 | Registered bell request, high only in alert |

## Verification
The level count is fixed at three, so the bench builds the block with the package defaults. Every transition and every input pair is then reachable within a handful of cycles. The stimulus walks each level under each of the four input combinations: no input, escalate only, clear only, and escalate together with clear. This covers saturation at the top level and clear priority at all three levels. The stimulus also applies a reset while the block is in alert. Between edges, the bench checks that no output moves before the clock edge that samples the input.

// File: rtl/alarm_lvl_pkg.sv
package alarm_lvl_pkg;
  localparam int LEVEL_COUNT = 3;
  localparam int CODE_W      = $clog2(LEVEL_COUNT);
  localparam int TOP_LEVEL   = LEVEL_COUNT - 1;

  typedef enum logic [CODE_W-1:0] {
    LVL_CALM  = 2'd0,
    LVL_WARN  = 2'd1,
    LVL_ALERT = 2'd2
  } level_e;
endpackage

// File: rtl/alarm_next_level.sv
module alarm_next_level
  import alarm_lvl_pkg::*;
(
  input  level_e cur_lvl,
  input  logic   bad_event,
  input  logic   clear,
  output level_e nxt_lvl
);
  always_comb begin
    nxt_lvl = cur_lvl;
    if (clear) begin
      nxt_lvl = LVL_CALM;
    end else if (bad_event) begin
      unique case (cur_lvl)
        LVL_CALM:  nxt_lvl = LVL_WARN;
        LVL_WARN:  nxt_lvl = LVL_ALERT;
        LVL_ALERT: nxt_lvl = LVL_ALERT;
        default:   nxt_lvl = LVL_CALM;
      endcase
    end
  end
endmodule

// File: rtl/alarm_out_decode.sv
module alarm_out_decode
  import alarm_lvl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  level_e                 nxt_lvl,
  output logic [LEVEL_COUNT-1:0] onehot_q,
  output logic                   bell_q
);
  logic [LEVEL_COUNT-1:0] onehot_d;

  for (genvar g = 0; g < LEVEL_COUNT; g++) begin : g_bit
    assign onehot_d[g] = (nxt_lvl == level_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      onehot_q <= LEVEL_COUNT'(1);
      bell_q   <= 1'b0;
    end else begin
      onehot_q <= onehot_d;
      bell_q   <= onehot_d[TOP_LEVEL];
    end
  end
endmodule

// File: rtl/alarm_level_fsm.sv
module alarm_level_fsm
  import alarm_lvl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bad_event_i,
  input  logic                   clear_i,
  output logic [CODE_W-1:0]      level_code_o,
  output logic [LEVEL_COUNT-1:0] level_onehot_o,
  output logic                   ring_bell_o
);
  level_e lvl_q;
  level_e lvl_d;

  alarm_next_level u_next (
    .cur_lvl   (lvl_q),
    .bad_event (bad_event_i),
    .clear     (clear_i),
    .nxt_lvl   (lvl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= LVL_CALM;
    else     lvl_q <= lvl_d;
  end

  alarm_out_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .nxt_lvl  (lvl_d),
    .onehot_q (level_onehot_o),
    .bell_q   (ring_bell_o)
  );

  assign level_code_o = lvl_q;
endmodule

// File: rtl/alarm_level_checker.sv
module alarm_level_checker
  import alarm_lvl_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   bad_event_i,
  input logic                   clear_i,
  input logic [CODE_W-1:0]      level_code_o,
  input logic [LEVEL_COUNT-1:0] level_onehot_o,
  input logic                   ring_bell_o
);
  p_reset_calm_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (level_code_o == 0 && level_onehot_o == 3'b001 && !ring_bell_o));

  p_calm_to_warn_r2: assert property (@(posedge clk) disable iff (rst)
    (level_code_o == 0 && bad_event_i && !clear_i) |=> (level_code_o == 1));

  p_warn_to_alert_r3: assert property (@(posedge clk) disable iff (rst)
    (level_code_o == 1 && bad_event_i && !clear_i) |=> (level_code_o == 2));

  p_alert_stays_r4: assert property (@(posedge clk) disable iff (rst)
    (level_code_o == 2 && !clear_i) |=> (level_code_o == 2));

  p_bell_alert_r5: assert property (@(posedge clk) disable iff (rst)
    ring_bell_o == (level_code_o == 2));

  p_clear_wins_r6_r7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (level_code_o == 0));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!bad_event_i && !clear_i) |=> ($stable(level_code_o) && $stable(level_onehot_o)));

  p_onehot_match_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones(level_onehot_o) == 1 && level_onehot_o[level_code_o]));
endmodule

bind alarm_level_fsm alarm_level_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .bad_event_i    (bad_event_i),
  .clear_i        (clear_i),
  .level_code_o   (level_code_o),
  .level_onehot_o (level_onehot_o),
  .ring_bell_o    (ring_bell_o)
);

// File: tb/alarm_level_fsm_tb_top.sv
module alarm_level_fsm_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bad = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] code;
  logic [2:0] onehot;
  logic       bell;

  int tests_run = 0;
  int tests_failed = 0;
  int model_lvl = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_level_fsm dut_i (
    .clk            (clk),
    .rst            (rst),
    .bad_event_i    (bad),
    .clear_i        (clr),
    .level_code_o   (code),
    .level_onehot_o (onehot),
    .ring_bell_o    (bell)
  );

  function automatic logic [5:0] pack_exp(int lvl);
    return {lvl[1:0], 3'b001 << lvl, (lvl == 2)};
  endfunction

  task automatic compare(logic [5:0] exp, string tag);
    logic [5:0] act;
    act = {code, onehot, bell};
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: got code=%0d onehot=%b bell=%b, expected code=%0d onehot=%b bell=%b",
               tag, act[5:4], act[3:1], act[0], exp[5:4], exp[3:1], exp[0]);
    end
  endtask

  // Driver: apply inputs at negedge, check nothing moved yet (R9), queue expectation
  task automatic step(logic b, logic c, string tag);
    logic [5:0] prev;
    @(negedge clk);
    prev = pack_exp(model_lvl);
    bad = b;
    clr = c;
    if (c) model_lvl = 0;
    else if (b && model_lvl < 2) model_lvl++;
    #1;
    compare(prev, "R9 outputs stable before edge");
    exp_q.push_back(pack_exp(model_lvl));
    tag_q.push_back(tag);
  endtask

  // Monitor: after each rising edge, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    tests_failed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(pack_exp(0), "R1 in reset");
    rst = 1'b0;
    @(posedge clk); #1;
    compare(pack_exp(0), "R1 after release");

    step(0, 0, "R8 hold calm");
    step(1, 0, "R2 calm to warn");
    step(0, 0, "R8 hold warn");
    step(1, 0, "R3 R5 warn to alert, bell on");
    step(1, 0, "R4 alert saturates");
    step(0, 0, "R8 hold alert");
    step(0, 1, "R6 clear from alert");
    step(1, 1, "R7 both in calm");
    step(1, 0, "R2 calm to warn");
    step(1, 1, "R7 both in warn");
    step(1, 0, "R2 again");
    step(0, 1, "R6 clear from warn");
    step(0, 1, "R6 clear in calm");
    step(1, 0, "R2 up");
    step(1, 0, "R3 up");
    step(1, 1, "R7 both in alert");
    step(1, 0, "R2 up");
    step(1, 0, "R3 R5 alert bell");
    step(0, 0, "R10 R5 alert steady");

    @(negedge clk);
    bad = 1'b0;
    clr = 1'b0;
    @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #1;
    compare(pack_exp(0), "R1 reset from alert");
    model_lvl = 0;
    @(negedge clk);
    rst = 1'b0;
    step(1, 0, "R2 after reset");
    step(0, 0, "R8 final hold");
    @(posedge clk); #3;
    finish_run();
  end
endmodule